// File: doc/BRIEF.md
# UART Receive Break Status

This block is the receive status path of a FIFO-buffered UART. The serial deserializer pushes 11-bit characters into a 16-deep receive FIFO. Each character holds the data byte plus three flags: parity error, framing error and a mark that the character arrived as a line break. The block shows the byte at the FIFO head on the receive buffer output. It builds the line status byte from the FIFO state and from a few sticky bits, and raises a receiver line status interrupt request when that request is enabled.

The break indicator follows only break characters that are really valid at the FIFO head. The FIFO read port keeps showing the last character it popped once the FIFO is empty. That stale word, and the short dip in the break level that occurs while a buffer read strobe is active, can never set the indicator again. A break character that software has already taken out therefore stays acknowledged after the next status read. The indicator is raised again only when another break character arrives.

Top module: `uart_rx_break_status`

## Requirements
- R1: After reset the FIFO is empty, all line status bits are 0, `rls_irq` is low and `rbr_data` is 0.
- R2: Line status bit 0 (data ready) is 1 exactly when the FIFO holds at least one character.
- R3: The FIFO stores up to 16 characters in arrival order. `rbr_data` is bits 7:0 of the head character. A pulse on `rbr_rd` removes the head character. A pulse on `rbr_rd` while the FIFO is empty changes nothing.
- R4: A write while the FIFO holds 16 characters is dropped, even if a read happens in the same cycle. The dropped write sets line status bit 1 (overrun). A line status read clears bit 1. If a dropped write and a line status read happen in the same cycle, bit 1 ends up set.
- R5: Line status bit 2 equals bit 8 (parity error) of the head character, and bit 3 equals bit 9 (framing error) of the head character. Both bits are 0 while the FIFO is empty.
- R6: The break level is defined as bit 10 of the head character, AND the FIFO is not empty, AND `rbr_rd` is low. Line status bit 4 (break) is set in the cycle after each low-to-high change of the break level.
- R7: A pulse on `lsr_rd` clears bit 4. If a rising edge of the break level falls in the same cycle as the `lsr_rd` pulse, bit 4 ends up set.
- R8: A break character that has been read out does not set bit 4 again. This holds even though the stale FIFO output still carries bit 10. After the last break character is read and then the line status is read, bit 4 stays 0 until a new break character reaches the head.
- R9: `rls_irq` is 1 exactly when `rls_irq_en` is 1 and at least one of line status bits 1 to 4 is 1.
- R10: Line status bits 7:5 always read 0. While the FIFO is empty, `rbr_data` shows the byte of the last character that was read, or 0 if no character has been read since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_wr_en | input | 1 | Character write strobe from the deserializer |
| rx_wr_data | input | 11 | Character: bit 10 break, bit 9 framing error, bit 8 parity error, bits 7:0 data |
| rbr_rd | input | 1 | Receive buffer read strobe; removes the head character |
| lsr_rd | input | 1 | Line status read strobe; clears the sticky status bits |
| rls_irq_en | input | 1 | Receiver line status interrupt enable |
| rbr_data | output | 8 | Data byte at the FIFO head (last byte read while empty) |
| lsr | output | 8 | Line status: bit 0 ready, 1 overrun, 2 parity, 3 framing, 4 break |
| rls_irq | output | 1 | Receiver line status interrupt request |

## Verification
The hardest state to reach is the one where the FIFO has just been emptied by reading a break character. In that state the stale output still carries the break flag and the status has been read once. The stimulus writes a single break character, waits for the indicator, and reads the buffer. It then reads the status and idles for several cycles, and the indicator must stay clear. Two further sequences cover related edges. In one, two break characters are written back to back, so the dip during the read produces a real new edge. In the other, a status read lands in the same cycle as a fresh break edge.

// File: rtl/uart_rx_stat_pkg.sv
package uart_rx_stat_pkg;

    localparam int ENTRY_W = 11;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_entry_t;

    localparam int LS_READY   = 0;
    localparam int LS_OVERRUN = 1;
    localparam int LS_PARITY  = 2;
    localparam int LS_FRAMING = 3;
    localparam int LS_BREAK   = 4;
    localparam int LS_W       = 8;

    function automatic logic [LS_W-1:0] pack_status(
        input logic ready, input logic ovr, input logic par,
        input logic frm,   input logic brk);
        logic [LS_W-1:0] v;
        v = '0;
        v[LS_READY]   = ready;
        v[LS_OVERRUN] = ovr;
        v[LS_PARITY]  = par;
        v[LS_FRAMING] = frm;
        v[LS_BREAK]   = brk;
        return v;
    endfunction

endpackage

// File: rtl/rxs_fifo.sv
module rxs_fifo
    import uart_rx_stat_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  rx_entry_t wr_data,
    input  logic      rd_en,
    output rx_entry_t head_o,
    output logic      empty_o,
    output logic      full_o,
    output logic      drop_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    rx_entry_t       mem [DEPTH];
    rx_entry_t       last_q;
    logic [AW-1:0]   rd_ptr, wr_ptr;
    logic [CW-1:0]   count;
    logic            push, pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    assign empty_o = (count == '0);
    assign full_o  = (count == FULL_CNT);
    assign push    = wr_en & ~full_o;
    assign pop     = rd_en & ~empty_o;
    assign drop_o  = wr_en & full_o;
    assign head_o  = empty_o ? last_q : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            last_q <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
                last_q <= mem[rd_ptr];
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_full_write_dropped_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full_o && !rd_en) |=> $stable(count));

    assert_empty_read_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty_o && !wr_en) |=> (empty_o && $stable(rd_ptr)));

endmodule

// File: rtl/rxs_break_det.sv
module rxs_break_det (
    input  logic clk,
    input  logic rst,
    input  logic head_brk,
    input  logic fifo_empty,
    input  logic rbr_rd,
    input  logic lsr_rd,
    output logic brk_flag
);
    logic lvl, lvl_q, rise;

    assign lvl  = head_brk & ~rbr_rd & ~fifo_empty;
    assign rise = lvl & ~lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q    <= 1'b0;
            brk_flag <= 1'b0;
        end else begin
            lvl_q <= lvl;
            if (rise)        brk_flag <= 1'b1;
            else if (lsr_rd) brk_flag <= 1'b0;
        end
    end

    assert_break_set_on_edge_R6: assert property (@(posedge clk) disable iff (rst)
        rise |=> brk_flag);

    assert_break_cleared_by_read_R7: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !rise) |=> !brk_flag);

    assert_no_stale_break_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |=> !$rose(brk_flag));

endmodule

// File: rtl/rxs_status.sv
module rxs_status
    import uart_rx_stat_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  rx_entry_t       head,
    input  logic            fifo_empty,
    input  logic            drop,
    input  logic            lsr_rd,
    input  logic            brk_flag,
    input  logic            irq_en,
    output logic [LS_W-1:0] lsr_o,
    output logic            irq_o
);
    logic ovr_q;
    logic par, frm;

    always_ff @(posedge clk) begin
        if (rst)         ovr_q <= 1'b0;
        else if (drop)   ovr_q <= 1'b1;
        else if (lsr_rd) ovr_q <= 1'b0;
    end

    assign par   = ~fifo_empty & head.perr;
    assign frm   = ~fifo_empty & head.ferr;
    assign lsr_o = pack_status(~fifo_empty, ovr_q, par, frm, brk_flag);
    assign irq_o = irq_en & (ovr_q | par | frm | brk_flag);

    assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        drop |=> lsr_o[LS_OVERRUN]);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq_o);

endmodule

// File: rtl/uart_rx_break_status.sv
module uart_rx_break_status
    import uart_rx_stat_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_wr_en,
    input  logic [10:0] rx_wr_data,
    input  logic        rbr_rd,
    input  logic        lsr_rd,
    input  logic        rls_irq_en,
    output logic [7:0]  rbr_data,
    output logic [7:0]  lsr,
    output logic        rls_irq
);
    rx_entry_t head;
    logic      empty, full, drop, brk_flag;

    rxs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .wr_en(rx_wr_en), .wr_data(rx_entry_t'(rx_wr_data)),
        .rd_en(rbr_rd),
        .head_o(head), .empty_o(empty), .full_o(full), .drop_o(drop)
    );

    rxs_break_det u_brk (
        .clk(clk), .rst(rst),
        .head_brk(head.brk), .fifo_empty(empty),
        .rbr_rd(rbr_rd), .lsr_rd(lsr_rd),
        .brk_flag(brk_flag)
    );

    rxs_status u_stat (
        .clk(clk), .rst(rst),
        .head(head), .fifo_empty(empty), .drop(drop),
        .lsr_rd(lsr_rd), .brk_flag(brk_flag), .irq_en(rls_irq_en),
        .lsr_o(lsr), .irq_o(rls_irq)
    );

    assign rbr_data = head.data;

    logic unused_full;
    assign unused_full = full;

endmodule

// File: tb/uart_rx_break_status_tb.sv
`timescale 1ns/1ps
module uart_rx_break_status_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        rx_wr_en;
    logic [10:0] rx_wr_data;
    logic        rbr_rd, lsr_rd, rls_irq_en;
    logic [7:0]  rbr_data, lsr;
    logic        rls_irq;

    always #2.5 clk = ~clk;

    uart_rx_break_status u_dut (
        .clk(clk), .rst(rst), .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data),
        .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .rls_irq_en(rls_irq_en),
        .rbr_data(rbr_data), .lsr(lsr), .rls_irq(rls_irq)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int q[$];
    int last_rd;
    bit m_bi, m_prev, m_oe;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        q.delete();
        last_rd = 0; m_bi = 0; m_prev = 0; m_oe = 0;
    endtask

    task automatic model_step(input bit wr, input int wd, input bit rr, input bit lr);
        bit emp, lvl, full;
        int hd;
        emp  = (q.size() == 0);
        hd   = emp ? last_rd : q[0];
        lvl  = hd[10] && !rr && !emp;
        m_bi = (lvl && !m_prev) ? 1'b1 : (lr ? 1'b0 : m_bi);
        m_prev = lvl;
        full = (q.size() == 16);
        m_oe = (wr && full) ? 1'b1 : (lr ? 1'b0 : m_oe);
        if (rr && !emp) last_rd = q.pop_front();
        if (wr && !full) q.push_back(wd);
    endtask

    task automatic compare();
        bit emp;
        int hd, pe, fe, err;
        emp = (q.size() == 0);
        hd  = emp ? last_rd : q[0];
        pe  = emp ? 0 : hd[8];
        fe  = emp ? 0 : hd[9];
        err = int'(m_oe) | pe | fe | int'(m_bi);
        chk("R2 ready", int'(lsr[0]), emp ? 0 : 1);
        chk("R3/R10 rbr_data", int'(rbr_data), hd & 8'hFF);
        chk("R4 overrun", int'(lsr[1]), int'(m_oe));
        chk("R5 parity", int'(lsr[2]), pe);
        chk("R5 framing", int'(lsr[3]), fe);
        chk("R6/R7/R8 break", int'(lsr[4]), int'(m_bi));
        chk("R10 reserved", int'(lsr[7:5]), 0);
        chk("R9 irq", int'(rls_irq), int'(rls_irq_en) & err);
    endtask

    task automatic cyc(input bit wr, input int wd, input bit rr, input bit lr);
        rx_wr_en   = wr;
        rx_wr_data = wd[10:0];
        rbr_rd     = rr;
        lsr_rd     = lr;
        @(posedge clk);
        model_step(wr, wd, rr, lr);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rx_wr_en = 0; rx_wr_data = '0; rbr_rd = 0; lsr_rd = 0;
        rls_irq_en = 1'b1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 lsr", int'(lsr), 0);
        chk("R1 irq", int'(rls_irq), 0);
        chk("R1 rbr_data", int'(rbr_data), 0);
        compare();

        // R3 plain data in order; R3 read on empty ignored
        cyc(0, 0, 1, 0);
        cyc(1, 'h041, 0, 0);
        cyc(1, 'h042, 0, 0);
        cyc(1, 'h043, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0);
        idle(2);

        // R8: lone break character read, then status read; stays clear
        cyc(1, 'h400, 0, 0);
        idle(2);
        cyc(0, 0, 1, 0);
        idle(2);
        cyc(0, 0, 0, 1);
        idle(5);

        // R7: status read while break still at head, no re-set
        cyc(1, 'h400, 0, 0);
        idle(1);
        cyc(0, 0, 0, 1);
        idle(3);
        cyc(0, 0, 1, 0);
        idle(2);

        // R6: two breaks back to back; second sets after dip
        cyc(1, 'h400, 0, 0);
        cyc(1, 'h455, 0, 0);
        idle(1);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 1, 0);
        idle(2);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 1, 0);
        cyc(0, 0, 0, 1);
        idle(3);

        // R7: rising edge coincides with status read: set wins
        cyc(1, 'h4AA, 0, 0);
        cyc(0, 0, 0, 1);
        idle(2);
        cyc(0, 0, 1, 1);
        cyc(0, 0, 0, 1);
        idle(2);

        // R5/R9: error flags and interrupt enable
        cyc(1, 'h112, 0, 0);
        cyc(1, 'h234, 0, 0);
        cyc(1, 'h056, 0, 0);
        idle(1);
        rls_irq_en = 1'b0;
        idle(1);
        rls_irq_en = 1'b1;
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0);
        idle(1);

        // R4: fill, overflow, same-cycle set and clear
        for (int i = 0; i < 16; i++) cyc(1, i + 'h60, 0, 0);
        cyc(1, 'h0EE, 0, 0);
        cyc(0, 0, 0, 1);
        cyc(1, 'h0EF, 1, 1);
        idle(1);
        cyc(0, 0, 0, 1);
        for (int i = 0; i < 17; i++) cyc(0, 0, 1, 0);
        idle(2);

        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            int w;
            w = int'($urandom_range(0, 2047));
            if (($urandom & 3) != 0) w = w & 'h0FF;
            rls_irq_en = ($urandom & 7) != 0;
            cyc(($urandom & 1) == 1, w, ($urandom % 3) == 0, ($urandom % 5) == 0);
        end

        // reset mid-run returns to R1 state
        rst = 1'b1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        chk("R1 lsr after reset", int'(lsr), 0);
        chk("R1 rbr after reset", int'(rbr_data), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule